// File: doc/BRIEF.md
# Byte/Word Arithmetic Unit With Status Flags

This block computes one arithmetic, move, shift or rotate operation per clock on either a 16-bit word or an 8-bit byte, and keeps a 16-bit flag word next to the result. Each operation that reports status writes six condition flags: carry, overflow, sign, zero, parity and half-carry. Three control bits (string direction, interrupt enable, single-step) sit in the same word. Only an explicit flag-load operation changes them. Arithmetic and shifts leave them alone.

A caller presents two operands, an opcode, a size select, a flag-write enable and an execute strobe. The result and the flag word are registered. They appear on the outputs one clock after the strobe. A flag-write enable lets a caller run an operation for its result alone and keep the previous flags.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, `res_o` and `flags_o` are zero, whatever the other inputs do.
- R2: When `exec_i` is high at a rising edge, the new result is on `res_o` after that edge. `op_i` encodes 0 move, 1 add, 2 subtract, 3 shift left, 4 shift right, 5 rotate left, 6 rotate right, 7 flag load. With `wide_i` low, only the low 8 bits of each operand are used and `res_o[15:8]` is zero.
- R3: The flag bit positions are: overflow bit 11, sign bit 7, zero bit 6, half-carry bit 4, parity bit 2 and carry bit 0. An add sets carry on a carry out of the operand's top bit and sets half-carry on a carry out of bit 3. It sets overflow when both operands have the same sign and the result has the other sign.
- R4: A subtract (a minus b) sets carry when unsigned a is less than b, and sets half-carry on a borrow into bit 4. It sets overflow when the operands have different signs and the result's sign differs from a's.
- R5: For every status-writing operation, sign is the result's top bit at the selected size. Zero is set only when the result is zero at that size. Parity is set when the low 8 bits of the result hold an even number of ones.
- R6: A shift by one puts the bit shifted out into carry and clears half-carry. For a left shift, overflow is the result's top bit XOR carry. For a right shift, overflow is the operand's top bit. Sign, zero and parity follow R5.
- R7: A rotate by one writes only carry and overflow. Carry is the bit that wrapped around. Overflow is the result's top bit XOR carry for a left rotate, and the XOR of the result's two top bits for a right rotate. All other flags keep their values.
- R8: A move copies `b_i` at the selected size to `res_o` and leaves every flag unchanged.
- R9: The direction (bit 10), interrupt (bit 9) and single-step (bit 8) bits change only on a flag load with `flag_we_i` high. A flag load copies all nine defined bits from `b_i` and leaves `res_o` unchanged. Bits 15:12, 5, 3 and 1 of `flags_o` are always zero.
- R10: With `flag_we_i` low, an executed operation updates `res_o` only and `flags_o` keeps its value. With `exec_i` low, neither output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Perform the operation this cycle |
| op_i | input | 3 | Operation code (see R2) |
| wide_i | input | 1 | 1 selects word operands, 0 selects byte operands |
| flag_we_i | input | 1 | Allow the operation to write the flag word |
| a_i | input | DW (16) | First operand |
| b_i | input | DW (16) | Second operand, the move source and the flag-load value |
| res_o | output | DW (16) | Registered result |
| flags_o | output | 16 | Registered flag word |

## Verification
The status write and the control-bit hold both act on the same flag register in one cycle. The bench first loads all three control bits to one. It then runs adds, subtracts, shifts and rotates whose status bits change in the same cycles. Each expected flag word is checked whole: the new status bits must appear and bits 10 to 8 must still be set. A second overlap is result-write against flag-hold. An add runs with the flag-write enable low and must produce a new result while the flag word stays as it was.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int FW = 16;

  localparam int B_OVF   = 11;
  localparam int B_DIR   = 10;
  localparam int B_INT   = 9;
  localparam int B_STEP  = 8;
  localparam int B_NEG   = 7;
  localparam int B_ZERO  = 6;
  localparam int B_HALF  = 4;
  localparam int B_PAR   = 2;
  localparam int B_CARRY = 0;

  localparam logic [FW-1:0] M_CTRL = (FW'(1) << B_DIR) | (FW'(1) << B_INT) | (FW'(1) << B_STEP);
  localparam logic [FW-1:0] M_STAT = (FW'(1) << B_OVF) | (FW'(1) << B_NEG) | (FW'(1) << B_ZERO)
                                   | (FW'(1) << B_HALF) | (FW'(1) << B_PAR) | (FW'(1) << B_CARRY);
  localparam logic [FW-1:0] M_ROT  = (FW'(1) << B_OVF) | (FW'(1) << B_CARRY);
  localparam logic [FW-1:0] M_LIVE = M_CTRL | M_STAT;

  typedef enum logic [2:0] {
    OP_MOV = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_SHL = 3'd3,
    OP_SHR = 3'd4,
    OP_ROL = 3'd5,
    OP_ROR = 3'd6,
    OP_LDF = 3'd7
  } alu_op_e;

  function automatic logic even_ones(input logic [7:0] v);
    return ~(^v);
  endfunction

  function automatic logic [FW-1:0] pack_status(input logic ovf, input logic neg, input logic zero,
                                                input logic half, input logic par, input logic carry);
    logic [FW-1:0] w;
    w = '0;
    w[B_OVF]   = ovf;
    w[B_NEG]   = neg;
    w[B_ZERO]  = zero;
    w[B_HALF]  = half;
    w[B_PAR]   = par;
    w[B_CARRY] = carry;
    return w;
  endfunction

endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          wide,
  output logic [DW-1:0] res,
  output logic          carry,
  output logic          half,
  output logic          ovf
);
  localparam int HW = DW / 2;

  logic [DW-1:0] b_eff;
  logic [DW:0]   word_sum;
  logic [HW:0]   byte_sum;
  logic          cout;
  logic          a_top, b_top, r_top;

  always_comb begin
    b_eff    = sub ? ~b : b;
    word_sum = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, sub};
    byte_sum = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, sub};
    res      = wide ? word_sum[DW-1:0] : {{HW{1'b0}}, byte_sum[HW-1:0]};
    cout     = wide ? word_sum[DW] : byte_sum[HW];
    carry    = cout ^ sub;
    half     = a[4] ^ b[4] ^ word_sum[4];
    a_top    = wide ? a[DW-1] : a[HW-1];
    b_top    = wide ? b_eff[DW-1] : b_eff[HW-1];
    r_top    = wide ? word_sum[DW-1] : byte_sum[HW-1];
    ovf      = (a_top == b_top) && (r_top != a_top);
  end

endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic          wide,
  input  logic [1:0]    kind,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          ovf
);
  localparam int HW = DW / 2;

  logic [DW-1:0] w_r;
  logic [HW-1:0] b_r;
  logic          w_c, b_c;
  logic          a_top, r_top, r_next;

  always_comb begin
    unique case (kind)
      2'd0: begin
        w_r = {a[DW-2:0], 1'b0};        w_c = a[DW-1];
        b_r = {a[HW-2:0], 1'b0};        b_c = a[HW-1];
      end
      2'd1: begin
        w_r = {1'b0, a[DW-1:1]};        w_c = a[0];
        b_r = {1'b0, a[HW-1:1]};        b_c = a[0];
      end
      2'd2: begin
        w_r = {a[DW-2:0], a[DW-1]};     w_c = a[DW-1];
        b_r = {a[HW-2:0], a[HW-1]};     b_c = a[HW-1];
      end
      default: begin
        w_r = {a[0], a[DW-1:1]};        w_c = a[0];
        b_r = {a[0], a[HW-1:1]};        b_c = a[0];
      end
    endcase
    res    = wide ? w_r : {{HW{1'b0}}, b_r};
    cout   = wide ? w_c : b_c;
    a_top  = wide ? a[DW-1] : a[HW-1];
    r_top  = wide ? w_r[DW-1] : b_r[HW-1];
    r_next = wide ? w_r[DW-2] : b_r[HW-2];
    unique case (kind)
      2'd1:    ovf = a_top;
      2'd3:    ovf = r_top ^ r_next;
      default: ovf = r_top ^ cout;
    endcase
  end

endmodule

// File: rtl/flag_alu_freg.sv
module flag_alu_freg
  import flag_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [FW-1:0] wr_mask,
  input  logic [FW-1:0] wr_val,
  output logic [FW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (wr)
      q <= ((q & ~wr_mask) | (wr_val & wr_mask)) & M_LIVE;
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_i,
  input  logic [2:0]    op_i,
  input  logic          wide_i,
  input  logic          flag_we_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic [FW-1:0] flags_o
);
  localparam int HW = DW / 2;

  alu_op_e       op;
  logic [DW-1:0] as_res, sh_res, nxt_res, mov_res;
  logic          as_carry, as_half, as_ovf;
  logic          sh_cout, sh_ovf;
  logic          is_arith, is_shift, is_rot;
  logic          r_neg, r_zero, r_par;
  logic [FW-1:0] st_val, st_mask;

  // internal events, visible to the bound checker
  logic          do_stat;
  logic          do_load;
  logic          res_we;

  assign op = alu_op_e'(op_i);

  flag_alu_addsub #(.DW(DW)) u_as (
    .a(a_i), .b(b_i), .sub(op == OP_SUB), .wide(wide_i),
    .res(as_res), .carry(as_carry), .half(as_half), .ovf(as_ovf)
  );

  flag_alu_shift #(.DW(DW)) u_sh (
    .a(a_i), .wide(wide_i), .kind(op_i[1:0] + 2'd1),
    .res(sh_res), .cout(sh_cout), .ovf(sh_ovf)
  );

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_SUB);
    is_shift = (op == OP_SHL) || (op == OP_SHR);
    is_rot   = (op == OP_ROL) || (op == OP_ROR);
    mov_res  = wide_i ? b_i : {{HW{1'b0}}, b_i[HW-1:0]};
    nxt_res  = is_arith ? as_res : ((is_shift || is_rot) ? sh_res : mov_res);
    r_neg    = wide_i ? nxt_res[DW-1] : nxt_res[HW-1];
    r_zero   = wide_i ? (nxt_res == '0) : (nxt_res[HW-1:0] == '0);
    r_par    = even_ones(nxt_res[7:0]);
  end

  always_comb begin
    st_val  = '0;
    st_mask = '0;
    if (is_arith) begin
      st_val  = pack_status(as_ovf, r_neg, r_zero, as_half, r_par, as_carry);
      st_mask = M_STAT;
    end else if (is_shift) begin
      st_val  = pack_status(sh_ovf, r_neg, r_zero, 1'b0, r_par, sh_cout);
      st_mask = M_STAT;
    end else if (is_rot) begin
      st_val  = pack_status(sh_ovf, 1'b0, 1'b0, 1'b0, 1'b0, sh_cout);
      st_mask = M_ROT;
    end else if (op == OP_LDF) begin
      st_val  = b_i[FW-1:0];
      st_mask = M_LIVE;
    end
  end

  assign do_stat = exec_i && flag_we_i && (is_arith || is_shift || is_rot);
  assign do_load = exec_i && flag_we_i && (op == OP_LDF);
  assign res_we  = exec_i && (op != OP_LDF);

  flag_alu_freg u_fr (
    .clk(clk), .rst_n(rst_n), .wr(do_stat || do_load),
    .wr_mask(st_mask), .wr_val(st_val), .q(flags_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      res_o <= '0;
    else if (res_we)
      res_o <= nxt_res;
  end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import flag_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exec_i,
  input logic [2:0]    op_i,
  input logic          wide_i,
  input logic          flag_we_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic [DW-1:0] res_o,
  input logic [FW-1:0] flags_o,
  input logic          do_stat,
  input logic          do_load
);

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & ~M_LIVE) == '0);

  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !do_load |=> $stable(flags_o[B_DIR:B_STEP]));

  p_we_low_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !flag_we_i) |=> $stable(flags_o));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> ($stable(flags_o) && $stable(res_o)));

  p_zero_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_stat && (op_i == OP_ADD || op_i == OP_SUB)) |=> (flags_o[B_ZERO] == (res_o == '0)));

  p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_stat && wide_i && op_i == OP_ADD) |=> (flags_o[B_CARRY] == ($past(a_i) > ~$past(b_i))));

  p_sub_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_stat && wide_i && op_i == OP_SUB) |=> (flags_o[B_CARRY] == ($past(a_i) < $past(b_i))));

  p_move_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && wide_i && op_i == OP_MOV) |=> ($stable(flags_o) && res_o == $past(b_i)));

  p_rot_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_stat && (op_i == OP_ROL || op_i == OP_ROR))
      |=> ($stable(flags_o[B_NEG]) && $stable(flags_o[B_ZERO]) && $stable(flags_o[B_HALF])
           && $stable(flags_o[B_PAR])));

  p_byte_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !wide_i && op_i != OP_LDF) |=> (res_o[DW-1:DW/2] == '0));

endmodule

bind flag_alu flag_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .wide_i(wide_i),
  .flag_we_i(flag_we_i), .a_i(a_i), .b_i(b_i), .res_o(res_o), .flags_o(flags_o),
  .do_stat(do_stat), .do_load(do_load)
);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;

  typedef struct {
    logic [15:0] res;
    logic [15:0] flg;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic        wide_i = 1'b1;
  logic        flag_we_i = 1'b1;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic [15:0] res_o;
  logic [15:0] flags_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  exp_t q[$];

  int m_res = 0;
  int m_flg = 0;

  always #2.5 clk = ~clk;

  flag_alu u0 (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .wide_i(wide_i),
    .flag_we_i(flag_we_i), .a_i(a_i), .b_i(b_i), .res_o(res_o), .flags_o(flags_o)
  );

  function automatic int bitv(input int v, input int pos);
    return (v >> pos) & 1;
  endfunction

  function automatic int setb(input int w, input int pos, input int val);
    return val != 0 ? (w | (1 << pos)) : (w & ~(1 << pos));
  endfunction

  // independent reference: integer arithmetic
  task automatic model(input int op, input bit wide, input int a, input int b,
                       input bit we, input bit ex);
    int mask, top, ua, ub, sa, sb, ss, r, cf, af, of, ones;
    bit status, rotate;
    if (!ex) return;
    mask = wide ? 'hFFFF : 'hFF;
    top  = wide ? 'h8000 : 'h80;
    ua = a & mask; ub = b & mask;
    sa = (ua >= top) ? ua - (mask + 1) : ua;
    sb = (ub >= top) ? ub - (mask + 1) : ub;
    r = m_res; cf = 0; af = 0; of = 0; status = 1; rotate = 0;
    case (op)
      0: begin r = ub; status = 0; end
      1: begin r = (ua + ub) & mask; cf = (ua + ub) > mask;
               af = ((ua & 15) + (ub & 15)) > 15; ss = sa + sb; of = (ss >= top) || (ss < -top); end
      2: begin r = (ua - ub) & mask; cf = ua < ub;
               af = (ua & 15) < (ub & 15); ss = sa - sb; of = (ss >= top) || (ss < -top); end
      3: begin r = (ua << 1) & mask; cf = (ua & top) != 0; of = ((r & top) != 0) != (cf != 0); end
      4: begin r = ua >> 1; cf = ua & 1; of = (ua & top) != 0; end
      5: begin cf = (ua & top) != 0; r = ((ua << 1) & mask) | cf;
               of = ((r & top) != 0) != (cf != 0); rotate = 1; end
      6: begin cf = ua & 1; r = (ua >> 1) | (cf != 0 ? top : 0);
               of = ((r & top) != 0) != ((r & (top >> 1)) != 0); rotate = 1; end
      default: begin status = 0; if (we) m_flg = b & 'h0FD5; end
    endcase
    if (op != 7) m_res = r;
    if (status && we) begin
      m_flg = setb(m_flg, 0, cf);
      m_flg = setb(m_flg, 11, of);
      if (!rotate) begin
        ones = 0;
        for (int i = 0; i < 8; i++) ones += bitv(r, i);
        m_flg = setb(m_flg, 4, af);
        m_flg = setb(m_flg, 7, (r & top) != 0);
        m_flg = setb(m_flg, 6, r == 0);
        m_flg = setb(m_flg, 2, (ones % 2) == 0);
      end
    end
  endtask

  task automatic run(input int op, input bit wide, input int a, input int b,
                     input bit we, input bit ex, input string tag);
    exp_t e;
    @(negedge clk);
    op_i = 3'(op); wide_i = wide; a_i = 16'(a); b_i = 16'(b);
    flag_we_i = we; exec_i = ex;
    model(op, wide, a, b, we, ex);
    e.res = 16'(m_res); e.flg = 16'(m_flg); e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: one expected item per clock, compared after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (res_o !== e.res || flags_o !== e.flg) begin
        fails++;
        $display("FAIL %s: res=%h flags=%h expected res=%h flags=%h",
                 e.tag, res_o, flags_o, e.res, e.flg);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs at zero while an operation is presented
    exec_i = 1'b1; op_i = 3'd1; a_i = 16'h1234; b_i = 16'h1111;
    repeat (3) @(negedge clk);
    tests++;
    if (res_o !== 16'h0 || flags_o !== 16'h0) begin
      fails++;
      $display("FAIL R1 reset: res=%h flags=%h expected res=0000 flags=0000", res_o, flags_o);
    end
    exec_i = 1'b0;
    rst_n = 1'b1;

    run(1, 1, 'h0123, 'h0025, 1, 1, "R3 word add 0123+0025");
    run(1, 1, 'h0148, 'h0148, 1, 1, "R3 half-carry 0148+0148");
    run(2, 1, 'h0148, 'h0148, 1, 1, "R4 self subtract zero");
    run(1, 0, 'hAB7F, 'hCD01, 1, 1, "R3 R2 byte add overflow, upper zero");
    run(1, 0, 'h12FF, 'h3401, 1, 1, "R3 byte carry wrap");
    run(2, 1, 'h8000, 'h0001, 1, 1, "R4 word subtract overflow");
    run(2, 0, 'h0010, 'h0021, 1, 1, "R4 byte borrow");
    run(1, 1, 'h00F0, 'h0003, 1, 1, "R5 parity even low byte");
    run(1, 1, 'h0100, 'h0001, 1, 1, "R5 parity odd, word nonzero");
    run(0, 1, 'h0000, 'hBEEF, 1, 1, "R8 move word keeps flags");
    run(0, 0, 'h0000, 'hBEEF, 1, 1, "R8 move byte");
    run(7, 1, 'h1111, 'hFFFF, 1, 1, "R9 flag load, result kept");
    run(1, 1, 'h0001, 'h0001, 1, 1, "R9 add with control bits kept");
    run(3, 1, 'h8001, 'h0000, 1, 1, "R6 shift left word");
    run(4, 1, 'h0001, 'h0000, 1, 1, "R6 shift right to zero");
    run(3, 0, 'h0040, 'h0000, 1, 1, "R6 R5 shift left byte sign");
    run(5, 0, 'h0080, 'h0000, 1, 1, "R7 rotate left byte");
    run(6, 1, 'h0001, 'h0000, 1, 1, "R7 rotate right word");
    run(1, 1, 'hFFFF, 'h0001, 0, 1, "R10 flag write disabled");
    run(2, 1, 'h0005, 'h0005, 1, 0, "R10 idle cycle");
    run(7, 1, 'h0000, 'h0000, 0, 1, "R9 load without enable");
    run(7, 1, 'h0000, 'h0500, 1, 1, "R9 partial control load");
    run(2, 1, 'h0000, 'h0001, 1, 1, "R4 R9 borrow with control bits");

    @(negedge clk);
    exec_i = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule